// File: doc/BRIEF.md
# Paged Effective Address Generator

This unit forms the first-level memory address for a 16-bit, word-addressed machine whose 64K-word space is split into 128 pages of 512 words. The page number sits in address bits [15:9] and the location within the page in bits [8:0]. Each cycle the unit sees the already-incremented program counter of the current instruction, the instruction word, the value of the base register that the instruction names, and a mode code. When the load strobe is high, it captures the address for that mode into a 16-bit memory address register.

There are three address sources, chosen by a three-input selector.

- **Direct and indirect modes:** the page number of the program counter is joined to the 9-bit in-page offset from the instruction. The two parts are concatenated, not added, so the result always lands on the instruction's own page.
- **Base mode:** a 6-bit offset, extended with zeros, is added to the base register. The sum wraps at 2^16, so it can reach any word.
- **Trap mode:** the 8-bit vector, extended with zeros, selects an entry in the table at the bottom of memory.

The load-effective-address mode computes the same page-joined value, but writes it to a separate result register as data and does not touch the memory address register. The unit does not perform the second memory read that indirect modes need. It only reports the mode it accepted and flags an indirect access.

Top module: `paged_ea_gen`

## Requirements
- R1: After a synchronous reset, `mar_o`, `lea_o`, `mode_o` and `indir_o` are all zero.
- R2: Mode code 0 (direct) with `load_i` high loads `mar_o` with {`pc_i[15:9]`, `instr_i[8:0]`} at the clock edge.
- R3: Mode code 1 (indirect) loads `mar_o` with the same page-joined value and sets `indir_o` to 1. Every other accepted mode clears `indir_o`.
- R4: Mode code 2 (base) loads `mar_o` with `base_i` plus `instr_i[5:0]` extended with zeros, modulo 2^16. For example, x2035 plus 12 gives x2041, and xFFFF plus 63 gives x003E.
- R5: Mode code 3 (trap) loads `mar_o` with `instr_i[7:0]` in the low byte and zeros in bits [15:8].
- R6: Mode code 4 (load effective address) loads `lea_o` with {`pc_i[15:9]`, `instr_i[8:0]`} and leaves `mar_o` unchanged. Modes 0 to 3 leave `lea_o` unchanged.
- R7: While `load_i` is low, all four outputs hold their values.
- R8: Mode codes 5, 6 and 7 are ignored even with `load_i` high, and all outputs hold.
- R9: `mode_o` shows the code of the most recently accepted mode, one edge after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | 16 | Incremented program counter of the current instruction |
| instr_i | input | 16 | Instruction word |
| base_i | input | 16 | Value of the base register the instruction names |
| mode_i | input | 3 | Addressing mode code (0 direct, 1 indirect, 2 base, 3 trap, 4 effective address) |
| load_i | input | 1 | Capture strobe |
| mar_o | output | 16 | Memory address register |
| lea_o | output | 16 | Effective-address result for the destination register |
| mode_o | output | 3 | Last accepted mode code |
| indir_o | output | 1 | Last accepted access was indirect |

## Verification
Every result is due exactly one rising edge after the cycle in which `load_i` and `mode_i` are presented, because each output comes straight from a register with no further stage. The bench changes inputs on the falling edge, lets one rising edge pass, and compares all four outputs on the next falling edge against a bench model that it advanced at that same edge. Because the comparison happens every cycle, holding behaviour is checked too: cycles with the strobe low, ignored mode codes and the register that the chosen mode must leave alone are all compared against the model.

// File: rtl/paged_ea_pkg.sv
package paged_ea_pkg;
  localparam int ADDR_W   = 16;
  localparam int MODE_W   = 3;

  typedef enum logic [MODE_W-1:0] {
    EA_DIRECT   = 3'd0,
    EA_INDIRECT = 3'd1,
    EA_BASE     = 3'd2,
    EA_TRAP     = 3'd3,
    EA_LEA      = 3'd4
  } ea_mode_e;

  typedef enum logic [1:0] {
    SEL_PAGE = 2'd0,
    SEL_SUM  = 2'd1,
    SEL_VEC  = 2'd2
  } mar_sel_e;
endpackage

// File: rtl/ea_page_join.sv
module ea_page_join #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 9
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int PAGE_W = ADDR_W - OFF_W;

  logic unused_pc_low;
  assign unused_pc_low = ^pc_i[OFF_W-1:0];

  // Page bits are taken from the counter, never carried into by the offset.
  assign addr_o = {pc_i[ADDR_W-1 -: PAGE_W], off_i};
endmodule

// File: rtl/ea_base_add.sv
module ea_base_add #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 6
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] sum_o
);
  logic [ADDR_W-1:0] off_ext;
  assign off_ext = {{(ADDR_W-OFF_W){1'b0}}, off_i};
  // Carry out of the top bit is dropped: the sum wraps at 2^ADDR_W.
  assign sum_o = base_i + off_ext;
endmodule

// File: rtl/ea_mar_sel.sv
module ea_mar_sel
  import paged_ea_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int VEC_W  = 8
) (
  input  mar_sel_e          sel_i,
  input  logic [ADDR_W-1:0] page_i,
  input  logic [ADDR_W-1:0] sum_i,
  input  logic [VEC_W-1:0]  vec_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] vec_ext;

  generate
    if (VEC_W < ADDR_W) begin : g_pad
      assign vec_ext = {{(ADDR_W-VEC_W){1'b0}}, vec_i};
    end else begin : g_full
      assign vec_ext = vec_i[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (sel_i)
      SEL_SUM: addr_o = sum_i;
      SEL_VEC: addr_o = vec_ext;
      default: addr_o = page_i;
    endcase
  end
endmodule

// File: rtl/paged_ea_gen.sv
module paged_ea_gen
  import paged_ea_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int PAGE_OFF = 9,
  parameter int BASE_OFF = 6,
  parameter int VEC_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] instr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              load_i,
  output logic [ADDR_W-1:0] mar_o,
  output logic [ADDR_W-1:0] lea_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              indir_o
);
  localparam int TOP_USED = (PAGE_OFF > VEC_W) ? PAGE_OFF : VEC_W;

  logic [ADDR_W-1:0] page_addr;
  logic [ADDR_W-1:0] sum_addr;
  logic [ADDR_W-1:0] sel_addr;
  mar_sel_e          sel;
  logic              accept;
  logic              mar_we;
  logic              lea_we;
  logic              unused_opc;

  assign unused_opc = ^instr_i[ADDR_W-1:TOP_USED];

  ea_page_join #(.ADDR_W(ADDR_W), .OFF_W(PAGE_OFF)) u_page (
    .pc_i   (pc_i),
    .off_i  (instr_i[PAGE_OFF-1:0]),
    .addr_o (page_addr)
  );

  ea_base_add #(.ADDR_W(ADDR_W), .OFF_W(BASE_OFF)) u_add (
    .base_i (base_i),
    .off_i  (instr_i[BASE_OFF-1:0]),
    .sum_o  (sum_addr)
  );

  always_comb begin
    case (mode_i)
      EA_BASE: sel = SEL_SUM;
      EA_TRAP: sel = SEL_VEC;
      default: sel = SEL_PAGE;
    endcase
  end

  ea_mar_sel #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_sel (
    .sel_i  (sel),
    .page_i (page_addr),
    .sum_i  (sum_addr),
    .vec_i  (instr_i[VEC_W-1:0]),
    .addr_o (sel_addr)
  );

  assign accept = load_i && (mode_i <= EA_LEA);
  assign mar_we = accept && (mode_i != EA_LEA);
  assign lea_we = accept && (mode_i == EA_LEA);

  always_ff @(posedge clk) begin
    if (rst) begin
      mar_o   <= '0;
      lea_o   <= '0;
      mode_o  <= '0;
      indir_o <= 1'b0;
    end else begin
      if (mar_we) mar_o <= sel_addr;
      if (lea_we) lea_o <= page_addr;
      if (accept) begin
        mode_o  <= mode_i;
        indir_o <= (mode_i == EA_INDIRECT);
      end
    end
  end

  // R2: direct address keeps the counter's page and the instruction offset
  a_r2_direct_page: assert property (@(posedge clk) disable iff (rst)
    (load_i && mode_i == EA_DIRECT) |=>
      (mar_o[PAGE_OFF-1:0] == $past(instr_i[PAGE_OFF-1:0]) &&
       mar_o[ADDR_W-1:PAGE_OFF] == $past(pc_i[ADDR_W-1:PAGE_OFF])));

  // R3: the indirect flag only accompanies an indirect mode report
  a_r3_indir_mode: assert property (@(posedge clk) disable iff (rst)
    indir_o |-> (mode_o == EA_INDIRECT));

  // R5: trap addresses stay inside the vector table
  a_r5_trap_low: assert property (@(posedge clk) disable iff (rst)
    (load_i && mode_i == EA_TRAP) |=> (mar_o[ADDR_W-1:VEC_W] == '0));

  // R6: effective-address mode never disturbs the address register
  a_r6_lea_keeps_mar: assert property (@(posedge clk) disable iff (rst)
    (load_i && mode_i == EA_LEA) |=> $stable(mar_o));

  // R7: no strobe, no change
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> ($stable(mar_o) && $stable(lea_o) && $stable(mode_o) && $stable(indir_o)));

  // R8: reserved codes are ignored
  a_r8_reserved: assert property (@(posedge clk) disable iff (rst)
    (load_i && mode_i > EA_LEA) |=> ($stable(mar_o) && $stable(lea_o) && $stable(mode_o)));
endmodule

// File: tb/tb_paged_ea_gen.sv
module tb_paged_ea_gen;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] pc_i, instr_i, base_i;
  logic [2:0]  mode_i;
  logic        load_i;
  logic [15:0] mar_o, lea_o;
  logic [2:0]  mode_o;
  logic        indir_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] e_mar, e_lea;
  logic [2:0]  e_mode;
  logic        e_ind;

  always #10 clk = ~clk;

  paged_ea_gen dut (
    .clk(clk), .rst(rst), .pc_i(pc_i), .instr_i(instr_i), .base_i(base_i),
    .mode_i(mode_i), .load_i(load_i), .mar_o(mar_o), .lea_o(lea_o),
    .mode_o(mode_o), .indir_o(indir_o)
  );

  function automatic logic [15:0] f_page(input logic [15:0] pc, input logic [15:0] ins);
    return {pc[15:9], ins[8:0]};
  endfunction

  function automatic logic [15:0] f_base(input logic [15:0] b, input logic [15:0] ins);
    return b + {10'd0, ins[5:0]};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " mar"}, mar_o, e_mar);
    chk({tag, " lea"}, lea_o, e_lea);
    chk({tag, " mode R9"}, {13'd0, mode_o}, {13'd0, e_mode});
    chk({tag, " indir R3"}, {15'd0, indir_o}, {15'd0, e_ind});
  endtask

  task automatic step(input logic [15:0] pc, input logic [15:0] ins, input logic [15:0] b,
                      input logic [2:0] m, input logic ld, input string tag);
    @(negedge clk);
    pc_i = pc; instr_i = ins; base_i = b; mode_i = m; load_i = ld;
    @(posedge clk);
    if (ld && m <= 3'd4) begin
      case (m)
        3'd0, 3'd1: e_mar = f_page(pc, ins);
        3'd2:       e_mar = f_base(b, ins);
        3'd3:       e_mar = {8'd0, ins[7:0]};
        default:    e_lea = f_page(pc, ins);
      endcase
      e_mode = m;
      e_ind  = (m == 3'd1);
    end
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; pc_i = '0; instr_i = '0; base_i = '0; mode_i = '0; load_i = 1'b0;
    e_mar = '0; e_lea = '0; e_mode = '0; e_ind = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_all("R1 reset");

    step(16'h2081, 16'h2044, 16'h0000, 3'd0, 1'b1, "R2 direct");
    step(16'hFE00, 16'h01FF, 16'h0000, 3'd0, 1'b1, "R2 top page");
    step(16'h2081, 16'hA044, 16'h0000, 3'd1, 1'b1, "R3 indirect");
    step(16'h0000, 16'h608C, 16'h2035, 3'd2, 1'b1, "R4 x2035+12");
    step(16'h0000, 16'h003F, 16'hFFFF, 3'd2, 1'b1, "R4 wrap");
    step(16'h0000, 16'hF025, 16'h1234, 3'd3, 1'b1, "R5 trap");
    step(16'h0000, 16'hF0FF, 16'h1234, 3'd3, 1'b1, "R5 trap max");
    step(16'h4A11, 16'hE1A5, 16'h0000, 3'd4, 1'b1, "R6 lea keeps mar");
    step(16'h1111, 16'h2022, 16'hBEEF, 3'd0, 1'b0, "R7 no load");
    step(16'h3333, 16'h2055, 16'hBEEF, 3'd5, 1'b1, "R8 code5");
    step(16'h3333, 16'h2055, 16'hBEEF, 3'd7, 1'b1, "R8 code7");
    step(16'h8000, 16'h0100, 16'h0000, 3'd1, 1'b1, "R9 indirect again");
    step(16'h8000, 16'h0100, 16'h0000, 3'd2, 1'b1, "R9 base clears indir R3");

    for (int i = 0; i < 400; i++) begin
      logic [2:0] m;
      logic ld;
      m  = 3'($urandom % 8);
      ld = (($urandom % 4) != 0);
      step(16'($urandom), 16'($urandom), 16'($urandom), m, ld,
           !ld ? "R7 rand" : (m > 3'd4) ? "R8 rand" :
           (m == 3'd4) ? "R6 rand" : (m == 3'd3) ? "R5 rand" :
           (m == 3'd2) ? "R4 rand" : (m == 3'd1) ? "R3 rand" : "R2 rand");
    end

    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    e_mar = '0; e_lea = '0; e_mode = '0; e_ind = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    check_all("R1 re-reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule